// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a physical address through a four-entry segment table. The two most significant address bits pick a table entry. The remaining twelve bits are an offset within that segment. Each entry holds a physical base, a length in bytes, a valid flag and three access-right bits. The physical address is the base of the selected entry plus the offset.

A privileged configuration port reloads the table, one entry per cycle. This is how the operating system swaps the translation context when it switches processes. Each request carries an address and an access kind: load, store or instruction fetch. One clock later the block returns either the translated address or a fault with a two-bit cause. The fault lets software build copy-on-write, zero-on-reference and growth of a stack or heap on top of the block.

Top module: `seg_xlate_unit`

## Requirements
- R1: The segment number is `req_vaddr[13:12]` and the offset is `req_vaddr[11:0]`. A successful translation returns base plus offset, truncated to 16 bits (the sum wraps modulo 2^16).
- R2: After reset, every table entry is invalid, `rsp_valid` is 0, `rsp_cause` is 00 and `rsp_paddr` is 0.
- R3: The offset never carries into the segment number. In a segment of length 0x1000, offset 0xFFF translates within that segment as base + 0xFFF.
- R4: A reference to an entry whose valid flag is clear faults with cause 01, whatever the access kind.
- R5: An offset greater than or equal to the entry length faults with cause 10 and returns `rsp_paddr` = 0. A length of 0 therefore faults on every offset.
- R6: The access-right bits are `cfg_perm[0]` read, `cfg_perm[1]` write and `cfg_perm[2]` execute. A request of kind 00 (load) needs read, 01 (store) needs write and 10 (fetch) needs execute. Kind 11 is reserved and always lacks the right. A missing right faults with cause 11 and returns `rsp_paddr` = 0.
- R7: When several faults apply, the cause reported is invalid (01) first, then bounds (10), then permission (11).
- R8: A request sampled with `req_valid` high at a clock edge produces `rsp_valid` = 1 with its result right after that edge. The response stays valid for that one cycle only. `rsp_fault` is 1 exactly when `rsp_cause` is not 00. With no request, `rsp_valid` is 0.
- R9: A table write (`cfg_we` high at an edge) replaces entry `cfg_idx` at that edge. A request in the same cycle sees the old contents. A request in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 2 | Entry to write |
| cfg_valid | input | 1 | Valid flag for the written entry |
| cfg_perm | input | 3 | Access rights: bit 0 read, bit 1 write, bit 2 execute |
| cfg_len | input | 13 | Segment length in bytes (0 to 4096) |
| cfg_base | input | 16 | Physical base of the segment |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 00 none, 01 invalid, 10 bounds, 11 permission |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |

## Verification
The table is loaded with a read-and-execute code segment, a read-write data segment, an empty entry and a read-only segment of full length. Each address is then tried with every access kind, so that the permission decode is told apart from the segment selection. Offsets just below, at and beyond each length separate a correct less-than compare from an off-by-one. Addresses that trip two faults at once pin down the priority order. A request issued in the same cycle as a table write, and then one in the next cycle, shows which contents a request sees. A base near the top of the physical range shows the sum wrapping.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_INVALID = 2'b01,
        CAUSE_BOUNDS  = 2'b10,
        CAUSE_PERM    = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'b00,
        KIND_STORE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    localparam int unsigned RIGHTS_W = 3;
    localparam int unsigned RIGHT_RD = 0;
    localparam int unsigned RIGHT_WR = 1;
    localparam int unsigned RIGHT_EX = 2;

endpackage

// File: rtl/sxu_seg_table.sv
module sxu_seg_table
    import sxu_pkg::*;
#(
    parameter int unsigned SEG_BITS = 2,
    parameter int unsigned LEN_W    = 13,
    parameter int unsigned PA_W     = 16,
    localparam int unsigned NUM_SEG = 1 << SEG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic                wr_valid,
    input  logic [RIGHTS_W-1:0] wr_rights,
    input  logic [LEN_W-1:0]    wr_len,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [SEG_BITS-1:0] rd_idx,
    output logic                rd_valid,
    output logic [RIGHTS_W-1:0] rd_rights,
    output logic [LEN_W-1:0]    rd_len,
    output logic [PA_W-1:0]     rd_base
);

    typedef struct packed {
        logic                valid;
        logic [RIGHTS_W-1:0] rights;
        logic [LEN_W-1:0]    len;
        logic [PA_W-1:0]     base;
    } slot_t;

    slot_t [NUM_SEG-1:0] slot_d, slot_q;
    slot_t               wr_slot;

    always_comb begin
        wr_slot.valid  = wr_valid;
        wr_slot.rights = wr_rights;
        wr_slot.len    = wr_len;
        wr_slot.base   = wr_base;
        slot_d = slot_q;
        for (int i = 0; i < int'(NUM_SEG); i++) begin
            if (wr_en && (wr_idx == SEG_BITS'(i))) begin
                slot_d[i] = wr_slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    // Read port shows registered contents: same-cycle writes are not visible.
    always_comb begin
        rd_valid  = slot_q[rd_idx].valid;
        rd_rights = slot_q[rd_idx].rights;
        rd_len    = slot_q[rd_idx].len;
        rd_base   = slot_q[rd_idx].base;
    end

    for (genvar g = 0; g < int'(NUM_SEG); g++) begin : g_slot_chk
        // R9: a write lands in the addressed slot at the next edge
        p_slot_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == SEG_BITS'(g)) |=>
                (slot_q[g].valid == $past(wr_valid) &&
                 slot_q[g].rights == $past(wr_rights) &&
                 slot_q[g].len == $past(wr_len) &&
                 slot_q[g].base == $past(wr_base)));
        // R9: an unaddressed slot keeps its contents
        p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == SEG_BITS'(g)) |=> $stable(slot_q[g]));
    end

endmodule

// File: rtl/sxu_check.sv
module sxu_check
    import sxu_pkg::*;
#(
    parameter int unsigned OFF_W = 12,
    parameter int unsigned LEN_W = 13,
    parameter int unsigned PA_W  = 16
) (
    input  logic [OFF_W-1:0]    offset,
    input  logic [1:0]          kind,
    input  logic                seg_valid,
    input  logic [RIGHTS_W-1:0] seg_rights,
    input  logic [LEN_W-1:0]    seg_len,
    input  logic [PA_W-1:0]     seg_base,
    output cause_e              cause,
    output logic [PA_W-1:0]     paddr
);

    logic             in_bounds;
    logic             has_right;
    logic [PA_W-1:0]  sum;

    always_comb begin
        in_bounds = LEN_W'(offset) < seg_len;
        unique case (kind_e'(kind))
            KIND_LOAD:  has_right = seg_rights[RIGHT_RD];
            KIND_STORE: has_right = seg_rights[RIGHT_WR];
            KIND_FETCH: has_right = seg_rights[RIGHT_EX];
            default:    has_right = 1'b0;
        endcase
        sum = seg_base + PA_W'(offset);

        if (!seg_valid) begin
            cause = CAUSE_INVALID;
        end else if (!in_bounds) begin
            cause = CAUSE_BOUNDS;
        end else if (!has_right) begin
            cause = CAUSE_PERM;
        end else begin
            cause = CAUSE_NONE;
        end
        paddr = (cause == CAUSE_NONE) ? sum : '0;
    end

endmodule

// File: rtl/sxu_rsp_stage.sv
module sxu_rsp_stage
    import sxu_pkg::*;
#(
    parameter int unsigned PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  cause_e          in_cause,
    input  logic [PA_W-1:0] in_paddr,
    output logic            out_valid,
    output logic            out_fault,
    output logic [1:0]      out_cause,
    output logic [PA_W-1:0] out_paddr
);

    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [1:0]      cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (in_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = (in_cause != CAUSE_NONE);
            rsp_d.cause = in_cause;
            rsp_d.paddr = in_paddr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign out_valid = rsp_q.valid;
    assign out_fault = rsp_q.fault;
    assign out_cause = rsp_q.cause;
    assign out_paddr = rsp_q.paddr;

    // R5/R6: a faulting response never exposes an address
    p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_paddr == '0));

    // R8: an idle output carries no cause
    p_idle_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_cause == 2'b00 && !out_fault));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import sxu_pkg::*;
#(
    parameter int unsigned VA_W     = 14,
    parameter int unsigned SEG_BITS = 2,
    parameter int unsigned PA_W     = 16,
    localparam int unsigned OFF_W   = VA_W - SEG_BITS,
    localparam int unsigned LEN_W   = OFF_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEG_BITS-1:0] cfg_idx,
    input  logic                cfg_valid,
    input  logic [2:0]          cfg_perm,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [PA_W-1:0]     cfg_base,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [1:0]          req_kind,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [1:0]          rsp_cause,
    output logic [PA_W-1:0]     rsp_paddr
);

    logic [SEG_BITS-1:0] seg_num;
    logic [OFF_W-1:0]    seg_off;
    logic                ent_valid;
    logic [2:0]          ent_rights;
    logic [LEN_W-1:0]    ent_len;
    logic [PA_W-1:0]     ent_base;
    cause_e              chk_cause;
    logic [PA_W-1:0]     chk_paddr;

    // R1/R3: fields are sliced apart; the offset path has no route to seg_num
    assign seg_num = req_vaddr[VA_W-1 -: SEG_BITS];
    assign seg_off = req_vaddr[OFF_W-1:0];

    sxu_seg_table #(
        .SEG_BITS (SEG_BITS),
        .LEN_W    (LEN_W),
        .PA_W     (PA_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_valid  (cfg_valid),
        .wr_rights (cfg_perm),
        .wr_len    (cfg_len),
        .wr_base   (cfg_base),
        .rd_idx    (seg_num),
        .rd_valid  (ent_valid),
        .rd_rights (ent_rights),
        .rd_len    (ent_len),
        .rd_base   (ent_base)
    );

    sxu_check #(
        .OFF_W (OFF_W),
        .LEN_W (LEN_W),
        .PA_W  (PA_W)
    ) u_check (
        .offset     (seg_off),
        .kind       (req_kind),
        .seg_valid  (ent_valid),
        .seg_rights (ent_rights),
        .seg_len    (ent_len),
        .seg_base   (ent_base),
        .cause      (chk_cause),
        .paddr      (chk_paddr)
    );

    sxu_rsp_stage #(
        .PA_W (PA_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_cause  (chk_cause),
        .in_paddr  (chk_paddr),
        .out_valid (rsp_valid),
        .out_fault (rsp_fault),
        .out_cause (rsp_cause),
        .out_paddr (rsp_paddr)
    );

    // R8: each accepted request yields exactly one response on the next cycle
    p_rsp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: an empty entry always reports the invalid cause
    p_invalid_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ent_valid) |=> (rsp_cause == 2'b01));

    // R5/R7: out of range on a live entry reports bounds even if rights are missing
    p_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ent_valid && (LEN_W'(seg_off) >= ent_len)) |=>
            (rsp_cause == 2'b10 && rsp_paddr == '0));

    // R6: a store to an entry without write right traps when in range
    p_store_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ent_valid && (LEN_W'(seg_off) < ent_len) &&
         req_kind == 2'b01 && !ent_rights[1]) |=> (rsp_cause == 2'b11));

    // R1: a clean translation equals base plus offset from the previous cycle
    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_cause == CAUSE_NONE) |=>
            (rsp_paddr == $past(ent_base + PA_W'(seg_off))));

endmodule

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_valid = 1'b0;
    logic [2:0]  cfg_perm = '0;
    logic [12:0] cfg_len = '0;
    logic [15:0] cfg_base = '0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [15:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_xlate_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_valid (cfg_valid),
        .cfg_perm  (cfg_perm),
        .cfg_len   (cfg_len),
        .cfg_base  (cfg_base),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .req_kind  (req_kind),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

    // vector: {req tag, vaddr, kind, expected cause, expected paddr}
    localparam int NV = 14;
    localparam logic [37:0] VECS [NV] = '{
        {4'd1, 14'h0240, 2'd2, 2'd0, 16'h4240}, // R1 fetch code
        {4'd1, 14'h0240, 2'd0, 2'd0, 16'h4240}, // R1 load code
        {4'd6, 14'h0240, 2'd1, 2'd3, 16'h0000}, // R6 store to code
        {4'd5, 14'h06FF, 2'd2, 2'd0, 16'h46FF}, // R5 last byte in range
        {4'd5, 14'h0700, 2'd2, 2'd2, 16'h0000}, // R5 first byte out
        {4'd7, 14'h0700, 2'd1, 2'd2, 16'h0000}, // R7 bounds beats permission
        {4'd1, 14'h1108, 2'd0, 2'd0, 16'h8108}, // R1 load data
        {4'd6, 14'h1108, 2'd1, 2'd0, 16'h8108}, // R6 store data allowed
        {4'd6, 14'h1108, 2'd2, 2'd3, 16'h0000}, // R6 fetch from data
        {4'd4, 14'h2000, 2'd0, 2'd1, 16'h0000}, // R4 empty entry
        {4'd7, 14'h2FFF, 2'd3, 2'd1, 16'h0000}, // R7 invalid beats all
        {4'd3, 14'h3FFF, 2'd0, 2'd0, 16'h2FFF}, // R3 top offset stays in seg
        {4'd6, 14'h3000, 2'd1, 2'd3, 16'h0000}, // R6 read-only store traps
        {4'd6, 14'h1108, 2'd3, 2'd3, 16'h0000}  // R6 reserved kind
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_seg(input logic [1:0] idx, input logic v, input logic [2:0] p,
                             input logic [12:0] len, input logic [15:0] base);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v; cfg_perm = p;
        cfg_len = len; cfg_base = base;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive at a falling edge, result is registered at the next rising edge
    task automatic request(input logic [13:0] va, input logic [1:0] kind);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] pack_rsp(input logic v, input logic f,
                                             input logic [1:0] c, input logic [15:0] a);
        return {12'd0, v, f, c, a};
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state at the outputs
        check("R2 reset rsp", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b0, 1'b0, 2'b00, 16'h0));
        rst_n = 1'b1;
        // R2: all entries start invalid
        request(14'h0000, 2'd0);
        check("R2 seg0 invalid after reset", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b1, 2'b01, 16'h0));
        request(14'h3000, 2'd0);
        check("R2 seg3 invalid after reset", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b1, 2'b01, 16'h0));
        // R8: idle cycle after a response
        @(negedge clk);
        check("R8 idle no response", {31'd0, rsp_valid}, 32'd0);

        write_seg(2'd0, 1'b1, 3'b101, 13'h0700, 16'h4000); // code: read+exec
        write_seg(2'd1, 1'b1, 3'b011, 13'h0500, 16'h8000); // data: read+write
        write_seg(2'd3, 1'b1, 3'b001, 13'h1000, 16'h2000); // read only, full length

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VECS[i];
            request(v[33:20], v[19:18]);
            check($sformatf("R%0d vector %0d", v[37:34], i),
                  pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
                  pack_rsp(1'b1, v[17:16] != 2'b00, v[17:16], v[15:0]));
        end

        // R8: back-to-back requests each answered in the following cycle
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 14'h0010; req_kind = 2'd0;
        @(negedge clk);
        check("R8 first of pair", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b0, 2'b00, 16'h4010));
        req_vaddr = 14'h1010; req_kind = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 second of pair", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b0, 2'b00, 16'h8010));
        @(negedge clk);
        check("R8 response lasts one cycle", {31'd0, rsp_valid}, 32'd0);

        // R9: write and request in the same cycle sees the old (empty) entry
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd2; cfg_valid = 1'b1; cfg_perm = 3'b011;
        cfg_len = 13'h0100; cfg_base = 16'hA000;
        req_valid = 1'b1; req_vaddr = 14'h2020; req_kind = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 same-cycle sees old", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b1, 2'b01, 16'h0));
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 next cycle sees new", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b0, 2'b00, 16'hA020));

        // R5: zero length faults even at offset 0
        write_seg(2'd2, 1'b1, 3'b111, 13'h0000, 16'hA000);
        request(14'h2000, 2'd0);
        check("R5 zero length", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b1, 2'b10, 16'h0));

        // R1: sum wraps modulo 2^16
        write_seg(2'd3, 1'b1, 3'b111, 13'h1000, 16'hF800);
        request(14'h3900, 2'd2);
        check("R1 wraparound", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b0, 2'b00, 16'h0100));

        // R3: top offset of full-length segment 2 stays in segment 2
        write_seg(2'd2, 1'b1, 3'b001, 13'h1000, 16'h1000);
        request(14'h2FFF, 2'd0);
        check("R3 no carry into segment", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b0, 2'b00, 16'h1FFF));

        // R4: clearing the valid flag revokes a live entry
        write_seg(2'd1, 1'b0, 3'b111, 13'h1000, 16'h8000);
        request(14'h1000, 2'd1);
        check("R4 revoked entry", pack_rsp(rsp_valid, rsp_fault, rsp_cause, rsp_paddr),
              pack_rsp(1'b1, 1'b1, 2'b01, 16'h0));

        done = 1'b1;
        finish_run();
    end

endmodule